// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a mode-register style configuration word into the column address stream of one SDRAM read or write burst. A load strobe captures the word. The block decodes the burst length, the wrap order, the CAS latency and the single-location write option. An illegal word leaves the previous settings in place and raises a sticky error flag.

A start strobe with a 9-bit column begins a burst. From the next clock on, the block presents one column address per cycle, with a valid flag and a flag that marks the final beat. The address wraps inside the aligned window that the burst length defines. The order inside the window is either counting (sequential) or XOR-based (interleaved). In full-page mode the address walks through all 512 columns and keeps going until a stop or a new start. A stop strobe ends the burst. A new start restarts the stream from the new column, the same way a fresh read or write interrupts a running burst.

Control is a two-state machine:
- `ST_IDLE`, the idle state: no address is valid. Transition *launch* goes to `ST_BURST` on a start strobe.
- `ST_BURST`, the burst state: one beat is issued per cycle. It has four transitions:
  - *restart*: a start strobe stays in `ST_BURST` and begins again at beat 0.
  - *abort*: a stop strobe without a start goes to `ST_IDLE`.
  - *finish*: the final beat without a start goes to `ST_IDLE`.
  - *advance*: otherwise the machine stays in `ST_BURST` with the next beat.

Top module: `sdram_colgen`

## Requirements
- R1: Mode bits [2:0] select the burst length: 000=1, 001=2, 010=4, 011=8 and 111=full page. A non-full burst issues exactly that many beats, raises `col_last` only on its final beat, and drops `col_valid` on the cycle after that beat.
- R2: With mode bit 3 = 0 (sequential), beat i has low window bits equal to (start + i) mod L, where L is the burst length. For example, L=8 from column 3 gives 3,4,5,6,7,0,1,2.
- R3: With mode bit 3 = 1 (interleave), beat i has low window bits equal to the start low bits XOR i. For example, L=8 from column 5 gives 5,4,7,6,1,0,3,2.
- R4: In full-page mode, beat i is (start + i) mod 512. `col_last` never rises, and the burst runs until a stop or a start.
- R5: Column bits above the burst window equal those of the start column for every beat of a non-full burst.
- R6: A load is rejected in any of these cases: a length code of 100, 101 or 110; bit 3 = 1 with length 111; or mode bits [6:4] other than 010 or 011. A rejected load sets `mode_err`, which stays set until reset, and keeps all previous settings.
- R7: Mode bits [6:4] of an accepted word set `cas_lat`: 010 gives 2 and 011 gives 3.
- R8: With mode bit 9 set, a burst started with `start_wr`=1 has length 1. A burst started with `start_wr`=0 keeps the programmed length.
- R9: A stop strobe sampled during a burst makes `col_valid` low from the next cycle. When start and stop arrive on the same edge, the start wins.
- R10: A start strobe sampled during a burst restarts the sequence. The next cycle shows beat 0 of the new column.
- R11: A start sampled at an edge gives beat 0 after that edge, then one beat per clock. The settings in force at the start edge govern the whole burst, and a load during the burst does not change it.
- R12: After reset, `col_valid`=0, `col_last`=0, `mode_err`=0 and `cas_lat`=3. The length is 1 and the order is sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Load strobe for the configuration word |
| mode_word | input | 12 | Configuration word |
| start | input | 1 | Burst start strobe |
| start_col | input | 9 | Start column of the burst |
| start_wr | input | 1 | Marks the started burst as a write |
| stop | input | 1 | Burst stop strobe |
| col_addr | output | 9 | Current column address (0 when not valid) |
| col_valid | output | 1 | Column address valid |
| col_last | output | 1 | Final beat of a non-full burst |
| cas_lat | output | 2 | Decoded CAS latency (2 or 3) |
| mode_err | output | 1 | Sticky flag for a rejected configuration load |

## Verification
A corrupted beat counter or captured window mask shows up on the very next beat. It appears as a wrong `col_addr` or as a `col_last` on the wrong beat, because every beat is compared with an address computed independently. A wrong state register shows as `col_valid` lasting one beat too long or ending one beat early, within one cycle of the last beat or of a stop. A bad configuration register stays hidden until the next burst or the next look at `cas_lat`. For that reason, each rejected load is followed by a burst and a `cas_lat` check.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_t;

    typedef struct packed {
        logic [2:0] len_code;
        logic       ilv;
        logic [1:0] cas;
        logic       single_wr;
    } mode_cfg_t;

    localparam int LEN_LSB   = 0;
    localparam int ILV_BIT   = 3;
    localparam int CAS_LSB   = 4;
    localparam int SWR_BIT   = 9;
    localparam logic [2:0] LEN_FULL = 3'b111;

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
    import sdram_colgen_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_cfg_t         cfg,
    output logic              err
);

    logic [2:0] len_in;
    logic [2:0] cas_in;
    logic       ilv_in;
    logic       bad_len;
    logic       bad_cas;
    logic       bad_mix;
    logic       reject;

    always_comb begin
        len_in  = word[LEN_LSB +: 3];
        cas_in  = word[CAS_LSB +: 3];
        ilv_in  = word[ILV_BIT];
        bad_len = (len_in == 3'b100) || (len_in == 3'b101) || (len_in == 3'b110);
        bad_cas = (cas_in != 3'b010) && (cas_in != 3'b011);
        bad_mix = ilv_in && (len_in == LEN_FULL);
        reject  = bad_len || bad_cas || bad_mix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.len_code  <= 3'b000;
            cfg.ilv       <= 1'b0;
            cfg.cas       <= 2'd3;
            cfg.single_wr <= 1'b0;
            err           <= 1'b0;
        end else if (load) begin
            if (reject) begin
                err <= 1'b1;
            end else begin
                cfg.len_code  <= len_in;
                cfg.ilv       <= ilv_in;
                cfg.cas       <= cas_in[1:0];
                cfg.single_wr <= word[SWR_BIT];
            end
        end
    end

    // R6: error flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(err));

    // R6: rejected load leaves settings untouched
    a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (load && reject) |=> (cfg == $past(cfg)) && err);

    // R7: stored latency is always 2 or 3
    a_r7_cas_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.cas == 2'd2) || (cfg.cas == 2'd3));

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic             stop,
    input  mode_cfg_t        cfg,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last
);

    burst_state_t     state_q, state_d;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;
    logic             full_q;
    logic [COL_W-1:0] mask_new;
    logic             full_new;
    logic             one_beat;

    function automatic logic [COL_W-1:0] f_mask(input logic [2:0] code);
        logic [COL_W-1:0] m;
        unique case (code)
            3'b000:  m = '0;
            3'b001:  m = COL_W'(1);
            3'b010:  m = COL_W'(3);
            3'b011:  m = COL_W'(7);
            default: m = '1;
        endcase
        return m;
    endfunction

    always_comb begin
        one_beat = start_wr && cfg.single_wr;
        full_new = !one_beat && (cfg.len_code == LEN_FULL);
        mask_new = one_beat ? '0 : f_mask(cfg.len_code);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_BURST;          // launch
            end
            ST_BURST: begin
                if (start)         state_d = ST_BURST;  // restart
                else if (stop)     state_d = ST_IDLE;   // abort
                else if (col_last) state_d = ST_IDLE;   // finish
                else               state_d = ST_BURST;  // advance
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            full_q <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            beat_q <= '0;
            mask_q <= mask_new;
            ilv_q  <= cfg.ilv;
            full_q <= full_new;
        end else if (state_q == ST_BURST) begin
            beat_q <= beat_q + COL_W'(1);
        end
    end

    // outputs
    always_comb begin
        col_valid = (state_q == ST_BURST);
        col_last  = col_valid && !full_q && (beat_q == mask_q);
        if (!col_valid)
            col_addr = '0;
        else if (ilv_q)
            col_addr = (base_q & ~mask_q) | ((base_q ^ beat_q) & mask_q);
        else
            col_addr = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
    end

    // R1: final beat ends the burst
    a_r1_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_valid);

    // R1: last only marks a valid beat
    a_r1_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R9: stop ends the burst on the next cycle
    a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start && col_valid) |=> !col_valid);

    // R10/R11: start shows beat 0 of the new column next cycle
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid && (col_addr == $past(start_col)));

    // R5: bits above the window stay fixed
    a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !start && !stop && !col_last && !full_q)
        |=> ((col_addr & ~mask_q) == ($past(col_addr) & ~mask_q)));

endmodule

// File: rtl/sdram_colgen.sv
module sdram_colgen
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_wr,
    input  logic              stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last,
    output logic [1:0]        cas_lat,
    output logic              mode_err
);

    mode_cfg_t cfg;

    colgen_mode_reg #(.MODE_W(MODE_W)) i_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .word  (mode_word),
        .cfg   (cfg),
        .err   (mode_err)
    );

    colgen_seq #(.COL_W(COL_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .start_wr  (start_wr),
        .stop      (stop),
        .cfg       (cfg),
        .col_addr  (col_addr),
        .col_valid (col_valid),
        .col_last  (col_last)
    );

    assign cas_lat = cfg.cas;

endmodule

// File: tb/test_sdram_colgen.sv
`timescale 1ns/1ps
module test_sdram_colgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [11:0] mode_word = '0;
    logic        start = 1'b0;
    logic [8:0]  start_col = '0;
    logic        start_wr = 1'b0;
    logic        stop = 1'b0;
    logic [8:0]  col_addr;
    logic        col_valid;
    logic        col_last;
    logic [1:0]  cas_lat;
    logic        mode_err;

    int checks = 0;
    int fails  = 0;

    // model of the accepted settings
    logic [2:0] m_len = 3'b000;
    logic       m_ilv = 1'b0;
    logic [1:0] m_cas = 2'd3;
    logic       m_sw  = 1'b0;
    logic       m_err = 1'b0;

    always #2 clk = ~clk;

    sdram_colgen i_sdram_colgen (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .start_wr(start_wr), .stop(stop),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
        .cas_lat(cas_lat), .mode_err(mode_err)
    );

    function automatic logic [11:0] mk(logic [2:0] len, logic ilv, logic [2:0] cas, logic sw);
        logic [11:0] w;
        w = '0;
        w[2:0] = len;
        w[3]   = ilv;
        w[6:4] = cas;
        w[9]   = sw;
        return w;
    endfunction

    function automatic logic [8:0] f_mask(logic [2:0] c);
        case (c)
            3'b000:  return 9'd0;
            3'b001:  return 9'd1;
            3'b010:  return 9'd3;
            3'b011:  return 9'd7;
            default: return 9'h1FF;
        endcase
    endfunction

    function automatic logic [8:0] f_addr(logic [8:0] col, int beat, logic [8:0] m, logic ilv);
        logic [8:0] b;
        b = 9'(beat);
        if (ilv) return (col & ~m) | ((col ^ b) & m);
        return (col & ~m) | ((col + b) & m);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_mode(logic [11:0] w);
        logic bad;
        @(negedge clk);
        mode_load = 1'b1;
        mode_word = w;
        @(negedge clk);
        mode_load = 1'b0;
        bad = (w[2:0] inside {3'b100, 3'b101, 3'b110}) ||
              (w[3] && w[2:0] == 3'b111) ||
              !(w[6:4] inside {3'b010, 3'b011});
        if (bad) m_err = 1'b1;
        else begin
            m_len = w[2:0]; m_ilv = w[3]; m_cas = w[5:4]; m_sw = w[9];
        end
        chk("R6 mode_err", int'(mode_err), int'(m_err));
        chk("R7 cas_lat", int'(cas_lat), int'(m_cas));
    endtask

    // runs one burst; stop_after = 0 means run to the last beat
    task automatic run_burst(logic [8:0] col, logic wr, int stop_after);
        logic [8:0] m;
        logic       full, ilv;
        m    = (wr && m_sw) ? 9'd0 : f_mask(m_len);
        full = !(wr && m_sw) && (m_len == 3'b111);
        ilv  = m_ilv;
        @(negedge clk);
        start = 1'b1; start_col = col; start_wr = wr;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; ; i++) begin
            logic lexp;
            lexp = !full && (i == int'(m));
            chk("R11 valid", int'(col_valid), 1);
            chk(ilv ? "R3 addr" : (full ? "R4 addr" : "R2 addr"),
                int'(col_addr), int'(f_addr(col, i, m, ilv)));
            chk("R1 last", int'(col_last), int'(lexp));
            if (lexp) break;
            if (stop_after != 0 && i == stop_after - 1) begin
                stop = 1'b1;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        stop = 1'b0;
        chk("R1/R9 valid drop", int'(col_valid), 0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 valid", int'(col_valid), 0);
        chk("R12 last", int'(col_last), 0);
        chk("R12 err", int'(mode_err), 0);
        chk("R12 cas", int'(cas_lat), 3);
        rst_n = 1'b1;
        run_burst(9'h0AB, 1'b0, 0);                    // R12 length 1

        // R2 / R3 directed orders
        load_mode(mk(3'b011, 1'b0, 3'b010, 1'b0));
        run_burst(9'd3, 1'b0, 0);
        load_mode(mk(3'b011, 1'b1, 3'b011, 1'b0));
        run_burst(9'd5, 1'b0, 0);
        run_burst(9'h1F5, 1'b1, 0);                    // R5 upper bits

        // R8 single-location writes
        load_mode(mk(3'b010, 1'b0, 3'b010, 1'b1));
        run_burst(9'h046, 1'b1, 0);
        run_burst(9'h046, 1'b0, 0);

        // R4 full page wraps past 511
        load_mode(mk(3'b111, 1'b0, 3'b011, 1'b0));
        run_burst(9'd500, 1'b0, 520);

        // R6 rejected loads keep settings
        load_mode(mk(3'b101, 1'b0, 3'b010, 1'b0));
        load_mode(mk(3'b111, 1'b1, 3'b010, 1'b0));
        load_mode(mk(3'b001, 1'b0, 3'b000, 1'b0));
        run_burst(9'd17, 1'b0, 40);                    // still full page

        // R9 stop mid burst
        load_mode(mk(3'b011, 1'b0, 3'b010, 1'b0));
        run_burst(9'd10, 1'b0, 3);

        // R10 restart with simultaneous stop; R11 load mid burst
        @(negedge clk);
        start = 1'b1; start_col = 9'd3; start_wr = 1'b0;
        @(negedge clk);
        start = 1'b0;
        mode_load = 1'b1; mode_word = mk(3'b000, 1'b0, 3'b010, 1'b0);
        chk("R10 beat0", int'(col_addr), 3);
        @(negedge clk);
        mode_load = 1'b0;
        m_len = 3'b000;
        chk("R11 unaffected", int'(col_addr), 4);
        chk("R11 not last", int'(col_last), 0);
        @(negedge clk);
        start = 1'b1; stop = 1'b1; start_col = 9'h125;
        chk("R11 beat2", int'(col_addr), 5);
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk("R10 restart valid", int'(col_valid), 1);
        chk("R10 restart addr", int'(col_addr), 9'h125);
        chk("R10 new length 1", int'(col_last), 1);
        @(negedge clk);
        chk("R10 end", int'(col_valid), 0);

        // constrained random
        for (int n = 0; n < 60; n++) begin
            logic [2:0] len;
            logic       ilv;
            int         sa;
            case ($urandom % 5)
                0: len = 3'b000;
                1: len = 3'b001;
                2: len = 3'b010;
                3: len = 3'b011;
                default: len = 3'b111;
            endcase
            ilv = (len == 3'b111) ? 1'b0 : 1'($urandom);
            load_mode(mk(len, ilv, 3'($urandom % 2 + 2), 1'($urandom)));
            sa = (len == 3'b111) ? int'($urandom % 30 + 1) :
                 (($urandom % 4 == 0) ? int'($urandom % 8 + 1) : 0);
            run_burst(9'($urandom), 1'($urandom), sa);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule